// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block models the erase side of a parallel NOR flash command interface. It watches bus write cycles (address, data, write strobe) and decodes the multi-cycle block-erase command. That command is either the six-cycle standard form or the two-cycle form accepted once a bypass mode has been entered. After the confirm write it opens a selection window. Each repeat of the confirm write adds another block to the list and restarts the window. When the window runs out, an erase engine sweeps the behavioural array one word per clock. It sets every word of each listed, unprotected block to all ones.

While the operation is pending, bus reads return a status byte instead of array data. Protected blocks are dropped without any error. A list made only of protected blocks still produces a short busy period. The sequencer accepts suspend and resume while the engine runs. An injected failure leaves the status visible until a reset command clears it. Window length, engine length and the short protected-only run are parameters counted in clock cycles.

Top module: `nor_erase_seq`

## Requirements
- R1: Out of reset the sequencer is in read mode. A read strobe returns, on the following cycle, array word i = block*2^WORD_BITS + word, where the block is address bits [ADDR_W-1 -: BLK_BITS] and the word is address bits [WORD_BITS-1:0]. The initial content of word i is (37*i+1) mod 256.
- R2: The standard sequence has six write cycles: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address of the target block. Command addresses are compared on bits [10:0]. From the next read onward, reads return status: bit7 busy, bit6 toggle, bit5 error, bit3 engine running, all other bits 0.
- R3: A wrong data or address value in any of the first five cycles returns the sequencer to read mode, and a following 30h write is ignored.
- R4: During the selection window, each further 30h write adds the block it addresses and restarts the TOUT_CYC window.
- R5: Once the window has expired the engine runs (status bit3 = 1), and a further 30h write adds no block.
- R6: The engine runs for at least ERASE_CYC cycles, sets every word of each selected unprotected block to FFh, leaves other blocks unchanged, and returns to read mode.
- R7: Blocks whose blk_lock bit is 1 are left unchanged while the other selected blocks are erased, and no error is flagged.
- R8: If every selected block is protected, the device is busy only for about PROT_CYC cycles after the window, which is shorter than a real erase, and the data stays unchanged.
- R9: Each status read taken while busy inverts the toggle bit, so two back-to-back status reads differ in bit6.
- R10: F0h during the selection window aborts to read mode with nothing erased. F0h while the engine runs is ignored.
- R11: B0h (any address) while the engine runs suspends it. Reads then return array data and progress freezes. A 30h write resumes the engine.
- R12: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode. In bypass mode, 80h at any address followed by 30h at a block address starts the erase. F0h in read mode leaves bypass mode.
- R13: fail_inj high during the engine run makes the operation end with reads returning status (bit5 = 1, bit7 = 0) until an F0h write restores read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data (command byte) |
| blk_lock | input | 2^BLK_BITS | Protection flag per block |
| fail_inj | input | 1 | Injected erase failure |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |

## Verification
The bench builds the default configuration: 8 blocks of 4 words, a 20-cycle selection window, a 48-cycle erase and a 12-cycle protected-only run. With only 32 words, the whole array is read back against a bench-side model after every operation. The short window lets the bench place a second confirm write just before expiry and still see the window open well past the first deadline. The gap between the 12-cycle and 48-cycle engine runs is wide enough that elapsed-cycle counts tell a skipped erase from a real one.

// File: rtl/nes_pkg.sv
package nes_pkg;
  localparam int CMD_AW = 11;
  localparam int DW     = 8;

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_C3, S_C4, S_C5, S_BYP, S_WIN, S_ERASE, S_SUSP, S_ERR
  } state_t;

  localparam logic [DW-1:0] CD_UNLK_A  = 8'hAA;
  localparam logic [DW-1:0] CD_UNLK_B  = 8'h55;
  localparam logic [DW-1:0] CD_SETUP   = 8'h80;
  localparam logic [DW-1:0] CD_CONFIRM = 8'h30;
  localparam logic [DW-1:0] CD_SUSP    = 8'hB0;
  localparam logic [DW-1:0] CD_RESET   = 8'hF0;
  localparam logic [DW-1:0] CD_BYPASS  = 8'h20;

  localparam logic [CMD_AW-1:0] AD_FIRST  = 11'h555;
  localparam logic [CMD_AW-1:0] AD_SECOND = 11'h2AA;

  localparam int ST_BUSY   = 7;
  localparam int ST_TOGGLE = 6;
  localparam int ST_ERR    = 5;
  localparam int ST_RUN    = 3;
endpackage

// File: rtl/nes_countdown.sv
module nes_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nes_bank.sv
module nes_bank import nes_pkg::*; #(
  parameter int BLK_BITS  = 3,
  parameter int WORD_BITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [BLK_BITS+WORD_BITS-1:0] rd_idx,
  output logic [DW-1:0]             rd_q,
  input  logic                      wipe_start,
  input  logic                      wipe_en,
  input  logic [(1<<BLK_BITS)-1:0]  wipe_mask
);
  localparam int IDX_W  = BLK_BITS + WORD_BITS;
  localparam int NWORDS = 1 << IDX_W;

  logic [DW-1:0] mem [NWORDS];
  logic [IDX_W:0] ptr;  // top bit marks the sweep as finished
  logic           wr;

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = DW'(i * 37 + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= {1'b1, {IDX_W{1'b0}}};
    end else if (wipe_start) begin
      ptr <= '0;
    end else if (wipe_en && !ptr[IDX_W]) begin
      ptr <= ptr + 1'b1;
    end
  end

  assign wr = wipe_en && !ptr[IDX_W] && wipe_mask[ptr[IDX_W-1 -: BLK_BITS]];

  always_ff @(posedge clk) begin
    if (wr) mem[ptr[IDX_W-1:0]] <= '1;
    if (rd_en) rd_q <= mem[rd_idx];
  end
endmodule

// File: rtl/nes_cmd_fsm.sv
module nes_cmd_fsm import nes_pkg::*; #(
  parameter int NBLK = 8,
  parameter int BW   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [BW-1:0]     blk,
  input  logic [NBLK-1:0]   blk_lock,
  input  logic              fail_inj,
  input  logic              win_zero,
  input  logic              eng_zero,
  output state_t            state_q,
  output logic              win_load,
  output logic              eng_load,
  output logic              eng_short,
  output logic [NBLK-1:0]   mask_q,
  output logic              err_q
);
  state_t          nxt;
  logic [NBLK-1:0] sel_q;
  logic            byp_q;
  logic            sel_new, sel_add, byp_set, byp_clr, err_clr;
  logic            hit_a, hit_b, hit_setup, hit_byp;
  logic            is_conf, is_rst, is_susp;

  assign hit_a     = we && wdata == CD_UNLK_A && cmd_addr == AD_FIRST;
  assign hit_b     = we && wdata == CD_UNLK_B && cmd_addr == AD_SECOND;
  assign hit_setup = we && wdata == CD_SETUP  && cmd_addr == AD_FIRST;
  assign hit_byp   = we && wdata == CD_BYPASS && cmd_addr == AD_FIRST;
  assign is_conf   = we && wdata == CD_CONFIRM;
  assign is_rst    = we && wdata == CD_RESET;
  assign is_susp   = we && wdata == CD_SUSP;
  assign eng_short = ((sel_q & ~blk_lock) == '0);

  always_comb begin
    nxt      = state_q;
    win_load = 1'b0;
    eng_load = 1'b0;
    sel_new  = 1'b0;
    sel_add  = 1'b0;
    byp_set  = 1'b0;
    byp_clr  = 1'b0;
    err_clr  = 1'b0;
    unique case (state_q)
      S_READ: begin
        if (byp_q) begin
          if (we && wdata == CD_SETUP) nxt = S_BYP;
          else if (is_rst)             byp_clr = 1'b1;
        end else if (hit_a) begin
          nxt = S_C1;
        end
      end
      S_C1: if (we) nxt = hit_b ? S_C2 : S_READ;
      S_C2: begin
        if (we) begin
          nxt = S_READ;
          if (hit_setup)    nxt = S_C3;
          else if (hit_byp) byp_set = 1'b1;
        end
      end
      S_C3: if (we) nxt = hit_a ? S_C4 : S_READ;
      S_C4: if (we) nxt = hit_b ? S_C5 : S_READ;
      S_C5, S_BYP: begin
        if (we) begin
          nxt = S_READ;
          if (is_conf) begin
            nxt      = S_WIN;
            sel_new  = 1'b1;
            win_load = 1'b1;
          end
        end
      end
      S_WIN: begin
        if (is_rst) begin
          nxt = S_READ;
        end else if (is_conf) begin
          sel_add  = 1'b1;
          win_load = 1'b1;
        end else if (win_zero) begin
          nxt      = S_ERASE;
          eng_load = 1'b1;
        end
      end
      S_ERASE: begin
        if (is_susp)       nxt = S_SUSP;
        else if (eng_zero) nxt = (err_q || fail_inj) ? S_ERR : S_READ;
      end
      S_SUSP: if (is_conf) nxt = S_ERASE;
      S_ERR: begin
        if (is_rst) begin
          nxt     = S_READ;
          err_clr = 1'b1;
        end
      end
      default: nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_READ;
      sel_q   <= '0;
      mask_q  <= '0;
      byp_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      if (sel_new)      sel_q <= NBLK'(1) << blk;
      else if (sel_add) sel_q <= sel_q | (NBLK'(1) << blk);
      if (eng_load)     mask_q <= sel_q & ~blk_lock;
      if (byp_set)      byp_q <= 1'b1;
      else if (byp_clr) byp_q <= 1'b0;
      if (err_clr)      err_q <= 1'b0;
      else if (state_q == S_ERASE && fail_inj) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq import nes_pkg::*; #(
  parameter int BLK_BITS  = 3,
  parameter int WORD_BITS = 2,
  parameter int ADDR_W    = CMD_AW + BLK_BITS,
  parameter int TOUT_CYC  = 20,
  parameter int ERASE_CYC = 48,
  parameter int PROT_CYC  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic                     bus_re,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic [(1<<BLK_BITS)-1:0] blk_lock,
  input  logic                     fail_inj,
  output logic [DW-1:0]            bus_rdata
);
  localparam int NBLK    = 1 << BLK_BITS;
  localparam int IDX_W   = BLK_BITS + WORD_BITS;
  localparam int CNT_TOP = (TOUT_CYC > ERASE_CYC) ? TOUT_CYC : ERASE_CYC;
  localparam int CW      = $clog2(CNT_TOP + 1);

  state_t          st;
  logic            win_load, eng_load, eng_short, win_zero, eng_zero, err_q;
  logic [NBLK-1:0] mask_q;
  logic [CW-1:0]   eng_val;
  logic [BLK_BITS-1:0] blk;
  logic [IDX_W-1:0]    idx;
  logic            busy, show_stat, tog_q, rd_sel_q;
  logic [DW-1:0]   stat_w, rd_stat_q, arr_q;

  assign blk = bus_addr[ADDR_W-1 -: BLK_BITS];
  assign idx = {blk, bus_addr[WORD_BITS-1:0]};

  nes_cmd_fsm #(.NBLK(NBLK), .BW(BLK_BITS)) u_fsm (
    .clk(clk), .rst(rst), .we(bus_we), .wdata(bus_wdata),
    .cmd_addr(bus_addr[CMD_AW-1:0]), .blk(blk), .blk_lock(blk_lock),
    .fail_inj(fail_inj), .win_zero(win_zero), .eng_zero(eng_zero),
    .state_q(st), .win_load(win_load), .eng_load(eng_load),
    .eng_short(eng_short), .mask_q(mask_q), .err_q(err_q)
  );

  nes_countdown #(.W(CW)) u_win (
    .clk(clk), .rst(rst), .load(win_load), .load_val(CW'(TOUT_CYC)),
    .en(st == S_WIN), .zero(win_zero)
  );

  assign eng_val = eng_short ? CW'(PROT_CYC) : CW'(ERASE_CYC);

  nes_countdown #(.W(CW)) u_eng (
    .clk(clk), .rst(rst), .load(eng_load), .load_val(eng_val),
    .en(st == S_ERASE), .zero(eng_zero)
  );

  nes_bank #(.BLK_BITS(BLK_BITS), .WORD_BITS(WORD_BITS)) u_bank (
    .clk(clk), .rst(rst), .rd_en(bus_re), .rd_idx(idx), .rd_q(arr_q),
    .wipe_start(eng_load), .wipe_en(st == S_ERASE), .wipe_mask(mask_q)
  );

  assign busy      = (st == S_WIN) || (st == S_ERASE);
  assign show_stat = busy || (st == S_ERR);

  always_comb begin
    stat_w            = '0;
    stat_w[ST_BUSY]   = busy;
    stat_w[ST_TOGGLE] = tog_q;
    stat_w[ST_ERR]    = err_q;
    stat_w[ST_RUN]    = (st == S_ERASE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q     <= 1'b0;
      rd_sel_q  <= 1'b0;
      rd_stat_q <= '0;
    end else if (bus_re) begin
      rd_sel_q  <= show_stat;
      rd_stat_q <= stat_w;
      if (busy) tog_q <= ~tog_q;
    end
  end

  assign bus_rdata = rd_sel_q ? rd_stat_q : arr_q;
endmodule

// File: rtl/nes_checker.sv
module nes_checker import nes_pkg::*; #(
  parameter int NBLK = 8,
  parameter int CW   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input logic            bus_re,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input state_t          state,
  input logic            err_q,
  input logic [NBLK-1:0] sel_q,
  input logic [CW-1:0]   eng_cnt
);
  logic busy;
  assign busy = (state == S_WIN) || (state == S_ERASE);

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(state == S_ERR && bus_we && bus_wdata == CD_RESET)) |=> err_q)
    else $error("error flag dropped without reset command"); // R13

  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (rst)
    (bus_re && state == S_ERR) |=> (bus_rdata[ST_ERR] && !bus_rdata[ST_BUSY]))
    else $error("error status not returned"); // R13

  AST_LIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state == S_ERASE) |=> $stable(sel_q))
    else $error("block list changed after window"); // R5

  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (state == S_SUSP) |=> $stable(eng_cnt))
    else $error("engine progressed while suspended"); // R11

  AST_WIN_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == S_WIN && bus_we && bus_wdata == CD_RESET) |=> (state == S_READ))
    else $error("reset during window did not abort"); // R10

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (bus_re && busy && $past(bus_re && busy)) |=> (bus_rdata[ST_TOGGLE] != $past(bus_rdata[ST_TOGGLE])))
    else $error("toggle bit did not alternate"); // R9
endmodule

bind nor_erase_seq nes_checker #(.NBLK(NBLK), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .state(st), .err_q(err_q),
  .sel_q(u_fsm.sel_q), .eng_cnt(u_eng.cnt)
);

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
  localparam int BB = 3, WB = 2, AW = 11 + BB;
  localparam int TO = 20, EC = 48, PC = 12;
  localparam int NB = 1 << BB, NW = 1 << (BB + WB);

  logic          clk = 1'b0, rst = 1'b1;
  logic          bus_we = 1'b0, bus_re = 1'b0, fail_inj = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [NB-1:0] blk_lock = '0;
  logic [7:0]    bus_rdata;
  logic [7:0]    model [NW];
  int            cyc = 0, n_chk = 0, n_fail = 0;
  bit            fin = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  nor_erase_seq #(.BLK_BITS(BB), .WORD_BITS(WB), .TOUT_CYC(TO),
                  .ERASE_CYC(EC), .PROT_CYC(PC)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .blk_lock(blk_lock),
    .fail_inj(fail_inj), .bus_rdata(bus_rdata)
  );

  function automatic logic [AW-1:0] ba(input int b, input int w);
    return AW'((b << 11) | w);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic std_seq(input int b);
    wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h80);
    wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(ba(b, 0), 8'h30);
  endtask

  // status always has bit0 = 0; word 0 (pattern 01h or FFh) has bit0 = 1
  task automatic wait_done(input string tag, output int t);
    logic [7:0] d;
    bit ok = 1'b0;
    for (int k = 0; k < 2000 && !ok; k++) begin
      rd(ba(0, 0), d);
      if (d[0] || !d[7]) ok = 1'b1;
    end
    chk(ok, tag, 0, 1);
    t = cyc;
  endtask

  task automatic wait_run(input string tag);
    logic [7:0] d;
    bit ok = 1'b0;
    for (int k = 0; k < 200 && !ok; k++) begin
      rd(ba(0, 0), d);
      if (!d[0] && d[7] && d[3]) ok = 1'b1;
    end
    chk(ok, tag, 0, 1);
  endtask

  task automatic wipe_model(input int b);
    for (int w = 0; w < (1 << WB); w++) model[b * (1 << WB) + w] = 8'hFF;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] d;
    for (int i = 0; i < NW; i++) begin
      rd(ba(i >> WB, i % (1 << WB)), d);
      chk(d == model[i], tag, d, model[i]);
    end
  endtask

  initial begin
    logic [7:0] d, d2;
    int t0, t1;
    for (int i = 0; i < NW; i++) model[i] = 8'(i * 37 + 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    sweep("R1 initial array");

    // R3: broken sequences
    wr(14'h555, 8'hAA); wr(14'h2AB, 8'h55); wr(ba(0, 0), 8'h30);
    rd(ba(0, 1), d); chk(d == model[1], "R3 bad address cycle 2", d, model[1]);
    wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h80);
    wr(14'h555, 8'hAA); wr(14'h2AA, 8'h54); wr(ba(0, 0), 8'h30);
    rd(ba(0, 2), d); chk(d == model[2], "R3 bad data cycle 5", d, model[2]);
    sweep("R3 array untouched");

    // R2, R9, R6: single block
    t0 = cyc;
    std_seq(1);
    rd(ba(0, 0), d);  chk((d & 8'h9F) == 8'h80, "R2 status after confirm", d & 8'h9F, 8'h80);
    rd(ba(0, 0), d2); chk(d2[6] != d[6], "R9 toggle alternates", d2, d ^ 8'h40);
    wait_done("R6 completion", t1);
    chk(t1 - t0 >= TO + EC, "R6 erase duration", t1 - t0, TO + EC);
    wipe_model(1);
    sweep("R6 block 1 erased");

    // R4: restart of window
    std_seq(2);
    repeat (14) @(negedge clk);
    rd(ba(0, 0), d); chk(d[7] && !d[3], "R4 window still open", d, 8'h80);
    wr(ba(3, 0), 8'h30);
    repeat (14) @(negedge clk);
    rd(ba(0, 0), d); chk(d[7] && !d[3], "R4 window restarted", d, 8'h80);
    wait_done("R4 completion", t1);
    wipe_model(2); wipe_model(3);
    sweep("R4 blocks 2 and 3 erased");

    // R5: late selection ignored
    std_seq(4);
    wait_run("R5 engine started");
    wr(ba(5, 0), 8'h30);
    wait_done("R5 completion", t1);
    wipe_model(4);
    sweep("R5 late block untouched");

    // R7: protected block skipped
    blk_lock = 8'b0100_0000;
    std_seq(6); wr(ba(0, 0), 8'h30);
    wait_done("R7 completion without error", t1);
    wipe_model(0);
    sweep("R7 protected block kept");

    // R8: all protected
    blk_lock = '1;
    t0 = cyc;
    std_seq(5);
    wait_done("R8 completion", t1);
    chk(t1 - t0 < TO + EC, "R8 short run", t1 - t0, TO + PC);
    chk(t1 - t0 >= TO + PC, "R8 run not skipped", t1 - t0, TO + PC);
    sweep("R8 data unchanged");
    blk_lock = '0;

    // R10: abort in window, ignored in engine
    std_seq(5);
    wr(ba(0, 0), 8'hF0);
    rd(ba(5, 1), d); chk(d == model[21], "R10 abort returns array", d, model[21]);
    repeat (100) @(negedge clk);
    sweep("R10 nothing erased");
    std_seq(7);
    wait_run("R10 engine started");
    wr(ba(0, 0), 8'hF0);
    rd(ba(0, 0), d); chk(d[7] && d[3], "R10 reset ignored in engine", d, 8'h88);
    wait_done("R10 completion", t1);
    wipe_model(7);
    sweep("R10 block 7 erased");

    // R11: suspend and resume
    std_seq(5);
    wait_run("R11 engine started");
    wr(ba(0, 0), 8'hB0);
    rd(ba(6, 0), d); chk(d == model[24], "R11 suspended reads array", d, model[24]);
    repeat (100) @(negedge clk);
    wr(ba(0, 0), 8'h30);
    rd(ba(0, 0), d); chk(d[7] && d[3], "R11 resumed still busy", d, 8'h88);
    wait_done("R11 completion", t1);
    wipe_model(5);
    sweep("R11 block 5 erased");

    // R12: bypass entry and short form
    wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h20);
    wr(ba(6, 0), 8'h80); wr(ba(6, 0), 8'h30);
    rd(ba(0, 0), d); chk((d & 8'h9F) == 8'h80, "R12 bypass erase started", d & 8'h9F, 8'h80);
    wait_done("R12 completion", t1);
    wipe_model(6);
    sweep("R12 block 6 erased");

    // R13: injected failure (still in bypass mode)
    wr(ba(0, 0), 8'h80); wr(ba(0, 0), 8'h30);
    wait_run("R13 engine started");
    @(negedge clk); fail_inj = 1'b1;
    @(negedge clk); fail_inj = 1'b0;
    wait_done("R13 completion", t1);
    rd(ba(3, 3), d); chk((d & 8'hA0) == 8'h20, "R13 error status", d & 8'hA0, 8'h20);
    rd(ba(2, 1), d); chk((d & 8'hA0) == 8'h20, "R13 error status persists", d & 8'hA0, 8'h20);
    wr(ba(0, 0), 8'hF0);
    rd(ba(0, 0), d); chk(d == 8'hFF, "R13 reset restores read mode", d, 8'hFF);

    // R12: leave bypass, short form no longer starts
    wr(ba(0, 0), 8'hF0);
    wr(ba(0, 0), 8'h80); wr(ba(0, 0), 8'h30);
    rd(ba(0, 0), d); chk(d == 8'hFF, "R12 bypass left", d, 8'hFF);
    sweep("R12 final array");

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-all actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule